// File: doc/BRIEF.md
# Fault-First Vector Length Truncation Controller

This controller sits beside a vector load/store sequencer and decides, element by element, what happens when a memory access would fault. The sequencer first hands over one command per vector instruction: the vector length, the predicate mask, the addressing mode and a fault-first enable. It then reports each element in index order, together with an indication that the access for that element would raise an exception.

Under fault-first, only the first active element (the lowest index whose predicate bit is set) behaves like a scalar access, so a fault there requests a normal trap. A would-be fault on any later active element does not trap. Instead the vector length is cut to that element's index and the loop ends. The controller also grants the memory request for every active element that has no fault. After an instruction has ended, it grants nothing further.

Both the command and the element reports are valid/ready streams. A transfer happens on a rising edge where valid and ready are both high. The sender holds its payload stable while valid is high and ready is low. `cmd_ready` is high only when the controller is idle and no result pulse is showing. `el_ready` is high only while a command is in progress. The result pins (`trap_req`, `done`, `vl_out`, `illegal_mode`) are plain registered pulses with no back-pressure.

Top module: `ffvl_trunc_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `done`, `trap_req`, `illegal_mode` and `el_ready` are 0.
- R2: A fault on the first active element raises `trap_req` for one cycle, in the cycle after that element's transfer. No `done` follows, and the instruction ends.
- R3: With fault-first enabled, a fault on an active element after the first active one raises no trap. `done` is set in the cycle after that element's transfer, with `vl_out` equal to the element's index.
- R4: Element i is active when predicate bit i is 1, and the first active element is the lowest such index. A fault on an inactive element is ignored: it causes no trap and no truncation, and that element gets no memory grant.
- R5: A command with fault-first enabled and addressing mode 2'b10 (vector indexed) is rejected, and so is any command with mode 2'b11. `illegal_mode` is high for one cycle after the command transfer, no element is accepted, and neither `done` nor `trap_req` is raised.
- R6: Fault-first is accepted with mode 2'b00 (unit stride) or 2'b01 (element strided). With fault-first disabled, modes 2'b00, 2'b01 and 2'b10 are all accepted, and every fault on an active element traps.
- R7: If no active element faults, `done` is set in the cycle after the last element (index VL-1), with `vl_out` equal to the command's VL. A command with VL 0 gives `done` with `vl_out` 0 in the cycle after the command transfer.
- R8: With an all-zero predicate mask, the instruction completes with `done` and `vl_out` equal to the command's VL, and raises no trap, whatever the fault inputs are.
- R9: Once an instruction has ended by trap, truncation or completion, `el_ready` and `mem_allow` stay 0 until a new command is accepted.
- R10: `done` and `trap_req` are single-cycle pulses. `cmd_ready` is 0 while a command is in progress and during any result pulse.
- R11: `mem_allow` is 1 exactly when an element transfer occurs for an active element whose fault input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_vl | input | VL_W | Vector length of the instruction (0..MAX_VL) |
| cmd_pred | input | MAX_VL | Predicate mask, bit i for element i |
| cmd_mode | input | 2 | Addressing mode: 00 unit, 01 strided, 10 indexed, 11 reserved |
| cmd_ff | input | 1 | Fault-first enable |
| el_valid | input | 1 | Element report valid |
| el_ready | output | 1 | Element report ready |
| el_idx | input | IDX_W | Element index, in increasing order from 0 |
| el_fault | input | 1 | The access for this element would fault |
| mem_allow | output | 1 | Grant for this element's memory request |
| trap_req | output | 1 | One-cycle request for a normal trap |
| done | output | 1 | One-cycle loop-done pulse |
| vl_out | output | VL_W | Resulting vector length, valid with `done` |
| illegal_mode | output | 1 | One-cycle pulse for a rejected mode combination |

## Verification
The bench builds the controller with MAX_VL set to 8. With that value, a full-length vector, a fault on the very last index and a mask with only the top bit set all fall within a few cycles. The random predicate masks and fault patterns also cover a large share of all first-active and first-fault position pairs. Directed instructions pin down VL 0, the all-zero mask, the rejected mode pairs and the difference between a first-element trap and a later-element truncation.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
  typedef enum logic [1:0] {
    AM_UNIT    = 2'b00,
    AM_STRIDE  = 2'b01,
    AM_INDEXED = 2'b10,
    AM_RSVD    = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    V_PASS  = 2'b00,
    V_LAST  = 2'b01,
    V_TRAP  = 2'b10,
    V_TRUNC = 2'b11
  } verdict_e;
endpackage

// File: rtl/ffvl_mode_check.sv
module ffvl_mode_check
  import ffvl_pkg::*;
(
  input  logic       ff_en,
  input  logic [1:0] mode,
  output logic       illegal
);
  addr_mode_e am;

  always_comb begin
    am = addr_mode_e'(mode);
    unique case (am)
      AM_UNIT, AM_STRIDE: illegal = 1'b0;
      AM_INDEXED:         illegal = ff_en;
      default:            illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ffvl_first_track.sv
module ffvl_first_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic mark,
  output logic seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen <= 1'b0;
    else if (clear) seen <= 1'b0;
    else if (mark)  seen <= 1'b1;
  end

  // R4
  seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !seen);
endmodule

// File: rtl/ffvl_verdict.sv
module ffvl_verdict
  import ffvl_pkg::*;
(
  input  logic     active,
  input  logic     fault,
  input  logic     seen,
  input  logic     ff_en,
  input  logic     last,
  output verdict_e verdict
);
  always_comb begin
    if (active && fault) begin
      if (!seen || !ff_en) verdict = V_TRAP;
      else                 verdict = V_TRUNC;
    end else if (last) begin
      verdict = V_LAST;
    end else begin
      verdict = V_PASS;
    end
  end
endmodule

// File: rtl/ffvl_trunc_ctrl.sv
module ffvl_trunc_ctrl
  import ffvl_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [VL_W-1:0]   cmd_vl,
  input  logic [MAX_VL-1:0] cmd_pred,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_ff,
  input  logic              el_valid,
  output logic              el_ready,
  input  logic [IDX_W-1:0]  el_idx,
  input  logic              el_fault,
  output logic              mem_allow,
  output logic              trap_req,
  output logic              done,
  output logic [VL_W-1:0]   vl_out,
  output logic              illegal_mode
);
  logic              busy_q;
  logic [VL_W-1:0]   vl_q;
  logic [MAX_VL-1:0] pred_q;
  logic              ff_q;
  logic              done_q, trap_q, ill_q;
  logic [VL_W-1:0]   vlout_q;

  logic     cmd_fire, el_fire;
  logic     bad_mode, seen, active, last;
  verdict_e verdict;

  assign cmd_ready = !busy_q && !done_q && !trap_q && !ill_q;
  assign el_ready  = busy_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign el_fire   = el_valid && el_ready;
  assign active    = pred_q[el_idx];
  assign last      = (VL_W'(el_idx) + VL_W'(1)) == vl_q;
  assign mem_allow = el_fire && active && !el_fault;

  ffvl_mode_check u_mode (
    .ff_en   (cmd_ff),
    .mode    (cmd_mode),
    .illegal (bad_mode)
  );

  ffvl_first_track u_first (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd_fire),
    .mark  (el_fire && active),
    .seen  (seen)
  );

  ffvl_verdict u_verdict (
    .active  (active),
    .fault   (el_fault),
    .seen    (seen),
    .ff_en   (ff_q),
    .last    (last),
    .verdict (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      vl_q    <= '0;
      pred_q  <= '0;
      ff_q    <= 1'b0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      ill_q   <= 1'b0;
      vlout_q <= '0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      ill_q  <= 1'b0;
      if (cmd_fire) begin
        vl_q   <= cmd_vl;
        pred_q <= cmd_pred;
        ff_q   <= cmd_ff;
        if (bad_mode) begin
          ill_q <= 1'b1;
        end else if (cmd_vl == '0) begin
          done_q  <= 1'b1;
          vlout_q <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end
      if (el_fire) begin
        unique case (verdict)
          V_TRAP: begin
            trap_q <= 1'b1;
            busy_q <= 1'b0;
          end
          V_TRUNC: begin
            done_q  <= 1'b1;
            vlout_q <= VL_W'(el_idx);
            busy_q  <= 1'b0;
          end
          V_LAST: begin
            done_q  <= 1'b1;
            vlout_q <= vl_q;
            busy_q  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign trap_req     = trap_q;
  assign done         = done_q;
  assign vl_out       = vlout_q;
  assign illegal_mode = ill_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);
  // R2
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && done));
  // R3
  trunc_shorter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vl_out <= vl_q);
  // R9
  no_req_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap_req) |-> (!el_ready && !mem_allow));
  // R5
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> (!el_ready && !done && !trap_req));
  // R11
  grant_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_allow |=> !trap_req);
  // R7
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    el_fire |-> VL_W'(el_idx) < vl_q);
endmodule

// File: tb/sim_ffvl_trunc_ctrl.sv
`timescale 1ns/1ps
module sim_ffvl_trunc_ctrl;
  localparam int MV = 8;
  localparam int IW = 3;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [VW-1:0] cmd_vl = '0;
  logic [MV-1:0] cmd_pred = '0;
  logic [1:0] cmd_mode = 2'b00;
  logic cmd_ff = 1'b0;
  logic el_valid = 1'b0;
  logic el_ready;
  logic [IW-1:0] el_idx = '0;
  logic el_fault = 1'b0;
  logic mem_allow, trap_req, done, illegal_mode;
  logic [VW-1:0] vl_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ffvl_trunc_ctrl #(.MAX_VL(MV)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vl(cmd_vl), .cmd_pred(cmd_pred), .cmd_mode(cmd_mode), .cmd_ff(cmd_ff),
    .el_valid(el_valid), .el_ready(el_ready), .el_idx(el_idx), .el_fault(el_fault),
    .mem_allow(mem_allow), .trap_req(trap_req), .done(done), .vl_out(vl_out),
    .illegal_mode(illegal_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // outcome kinds: 0 done, 1 trap, 2 illegal
  int exp_kind, exp_vl, exp_n;

  function automatic bit mode_bad(input logic [1:0] m, input logic ff);
    return (m == 2'b11) || (ff && m == 2'b10);
  endfunction

  task automatic model(input int vl, input logic [MV-1:0] pred,
                       input logic [1:0] mode, input logic ff,
                       input logic [MV-1:0] flt);
    bit seen = 0;
    exp_kind = 0; exp_vl = vl; exp_n = vl;
    if (mode_bad(mode, ff)) begin
      exp_kind = 2; exp_n = 0; return;
    end
    for (int i = 0; i < vl; i++) begin
      if (pred[i] && flt[i]) begin
        exp_n = i + 1;
        if (!seen || !ff) exp_kind = 1;
        else exp_vl = i;
        return;
      end
      if (pred[i]) seen = 1;
    end
  endtask

  task automatic run_one(input int vl, input logic [MV-1:0] pred,
                         input logic [1:0] mode, input logic ff,
                         input logic [MV-1:0] flt, input string req);
    model(vl, pred, mode, ff, flt);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_vl = VW'(vl); cmd_pred = pred;
    cmd_mode = mode; cmd_ff = ff;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      el_valid = 1'b1; el_idx = IW'(i); el_fault = flt[i];
      @(negedge clk);
      check(el_ready == 1'b1, {req, " R10 el_ready"}, el_ready, 1);
      check(cmd_ready == 1'b0, {req, " R10 cmd_ready busy"}, cmd_ready, 0);
      check(mem_allow == (pred[i] && !flt[i]), {req, " R11 R4 mem_allow"},
            mem_allow, pred[i] && !flt[i]);
      @(posedge clk); #1;
    end
    // offer the next element after the end to observe blocking (R9)
    el_valid = (exp_kind != 2) && (exp_n < vl);
    el_idx = IW'(exp_n); el_fault = 1'b0;
    @(negedge clk);
    check(done == (exp_kind == 0), {req, " done"}, done, exp_kind == 0);
    check(trap_req == (exp_kind == 1), {req, " trap_req"}, trap_req, exp_kind == 1);
    check(illegal_mode == (exp_kind == 2), {req, " R5 illegal_mode"},
          illegal_mode, exp_kind == 2);
    if (exp_kind == 0) check(vl_out == VW'(exp_vl), {req, " vl_out"}, vl_out, exp_vl);
    check(!el_ready && !mem_allow, {req, " R9 blocked"}, mem_allow, 0);
    check(cmd_ready == 1'b0, {req, " R10 cmd_ready pulse"}, cmd_ready, 0);
    @(posedge clk); #1;
    el_valid = 1'b0;
    @(negedge clk);
    check(!done && !trap_req && !illegal_mode, {req, " R10 single pulse"},
          done | trap_req, 0);
    check(!el_ready && !mem_allow, {req, " R9 still blocked"}, el_ready, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    check(!done && !trap_req && !illegal_mode && !el_ready, "R1 outputs idle",
          done | trap_req | illegal_mode | el_ready, 0);

    run_one(4, 8'hFF, 2'b00, 1'b1, 8'h00, "R7 no fault");
    run_one(5, 8'hFF, 2'b00, 1'b1, 8'h01, "R2 first fault");
    run_one(6, 8'hFF, 2'b00, 1'b1, 8'h04, "R3 later fault");
    run_one(6, 8'hFC, 2'b01, 1'b1, 8'h07, "R4 first active idx2");
    run_one(6, 8'hF8, 2'b00, 1'b1, 8'h13, "R4 inactive faults ignored");
    run_one(4, 8'hFF, 2'b10, 1'b1, 8'h00, "R5 indexed ff");
    run_one(4, 8'hFF, 2'b11, 1'b0, 8'h00, "R5 reserved mode");
    run_one(6, 8'hFF, 2'b10, 1'b0, 8'h08, "R6 no ff trap indexed");
    run_one(6, 8'hFF, 2'b01, 1'b1, 8'h02, "R6 strided trunc");
    run_one(0, 8'hFF, 2'b00, 1'b1, 8'hFF, "R7 zero vl");
    run_one(8, 8'h00, 2'b00, 1'b1, 8'hFF, "R8 zero mask");
    run_one(8, 8'hFF, 2'b00, 1'b1, 8'h80, "R3 last index trunc");
    run_one(8, 8'h80, 2'b01, 1'b1, 8'h80, "R2 top bit only trap");

    for (int n = 0; n < 300; n++) begin
      int vl = $urandom_range(0, MV);
      logic [MV-1:0] pred = MV'($urandom) | MV'($urandom);
      logic [MV-1:0] flt  = MV'($urandom) & MV'($urandom) & MV'($urandom);
      logic [1:0] mode = 2'($urandom_range(0, 3));
      logic ff = ($urandom_range(0, 3) != 0);
      if ((n % 4) != 0 && mode == 2'b11) mode = 2'b00;
      run_one(vl, pred, mode, ff, flt, "random R2 R3 R6 R7");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule